// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus that looks, to a bus controller, like a small serial EEPROM. The bus clock and data lines are sampled with the fast system clock. Start and stop conditions are recovered from the sampled lines. A control byte picks the device and the transfer direction. Data bytes are then written into, or read out of, an internal byte array.

An address pointer is kept inside the block and survives from one transfer to the next. A write transfer first loads the pointer and then stores bytes at it. The pointer wraps inside a 16-byte page while bytes are being stored. A read transfer returns bytes starting at the pointer and moves the pointer forward, wrapping at the top of the array. A random read is a write that carries only the address, followed by a repeated start and a read control byte. The data line is only ever pulled low: the output enable asks the pad to sink the line, and the line is otherwise released.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A start condition (data line falling while the bus clock is high) restarts control-byte reception from any state, including in the middle of a partly received byte. A stop condition (data line rising while the clock is high) returns the block to idle with the line released.
- R2: The control byte is acknowledged only when its top four bits are 1010 and bits 3..1 equal `sel_strap_i`. Bit 0 selects the direction: 1 means read and 0 means write. A control byte that does not match gets no acknowledge. The block then acknowledges nothing, drives nothing and stores nothing until the next start.
- R3: After each byte it accepts (control, address or write data), the block pulls the data line low for the ninth clock and releases it after that clock's falling edge.
- R4: In a write transfer, the byte after the control byte loads the address pointer, and each following byte is stored at the pointer.
- R5: After each stored byte, the low 4 bits of the pointer increment and wrap within the 16-byte page, while the upper pointer bits stay unchanged.
- R6: A read control byte with no address first (current-address read) returns the byte at the pointer left by the previous transfer.
- R7: A write control byte plus an address, then a repeated start and a read control byte, returns the byte stored at that address.
- R8: In a read, the pointer advances by one after each byte sent and wraps from the top address to 0. An acknowledge from the controller makes the block send the next byte.
- R9: When the controller does not acknowledge a byte sent by the block (the line stays high on the ninth clock), the block releases the line and drives nothing until the next start.
- R10: The block changes the data line only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Bus clock line as seen at the pad |
| bus_dat_i | input | 1 | Data line as seen at the pad (wired-AND level) |
| bus_dat_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| sel_strap_i | input | 3 | Chip-select strap that control byte bits 3..1 must match |

## Verification
The hardest condition to reach is a repeated start that arrives in the middle of a data byte, after the address is loaded but before eight bits are in. That partial byte must be dropped, and the pointer must stay where the address put it. The bench drives four bits of a data byte, issues a start, and then reads back with a current-address read. A second hard case is pointer wrap at the top of the array during a sequential read. Before reading across the boundary, the bench writes bytes at the last address and at address 0 with two separate single-byte writes.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_ACK_TX,
    ST_RDATA,
    ST_ACK_RX
  } eep_state_e;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line_i,
  input  logic dat_line_i,
  output logic clk_s_o,
  output logic dat_s_o,
  output logic clk_rise_o,
  output logic clk_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {dat_line_i, clk_line_i};

  // one synchronizer chain per bus line; idle bus level is high
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[g] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[g]};
        prev[g] <= chain[STAGES-1];
      end
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign clk_s_o    = synced[0];
  assign dat_s_o    = synced[1];
  assign clk_rise_o = synced[0] & ~prev[0];
  assign clk_fall_o = ~synced[0] & prev[0];
  assign start_o    = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_o     = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         PAGE_W   = 4,
  parameter int         SEL_W    = 3,
  parameter int         SYNC_N   = 2,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_clk_i,
  input  logic             bus_dat_i,
  output logic             bus_dat_oe_o,
  input  logic [SEL_W-1:0] sel_strap_i
);

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int IDX_W  = $clog2(DATA_W);

  // pointer step while storing: wrap inside the page
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  // pointer step while reading: wrap at array top
  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic ctrl_hit(input logic [DATA_W-1:0] b,
                                    input logic [SEL_W-1:0]  s);
    return (b[DATA_W-1:DATA_W-4] == DEV_TYPE) && (b[SEL_W:1] == s);
  endfunction

  // bus line events
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_sync #(.STAGES(SYNC_N)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_line_i (bus_clk_i),
    .dat_line_i (bus_dat_i),
    .clk_s_o    (scl_s),
    .dat_s_o    (sda_s),
    .clk_rise_o (scl_rise),
    .clk_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eep_state_e        st, after_ack;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg, txreg;
  logic [ADDR_W-1:0] ptr;
  logic              oe, mack;
  logic [DATA_W-1:0] rd_data;

  // named internal events
  logic              receiving, byte_full, byte_end, ctrl_ok;
  logic              wr_en, tx_done, tx_load, ctrl_reject, nack_end;
  logic [IDX_W-1:0]  tx_idx;

  assign receiving   = (st == ST_CTRL) || (st == ST_ADDR) || (st == ST_WDATA);
  assign byte_full   = (bitcnt == CNT_W'(DATA_W));
  assign byte_end    = receiving && scl_fall && byte_full;
  assign ctrl_ok     = ctrl_hit(shreg, sel_strap_i);
  assign ctrl_reject = byte_end && (st == ST_CTRL) && !ctrl_ok;
  assign wr_en       = byte_end && (st == ST_WDATA);
  assign tx_done     = (st == ST_RDATA) && scl_fall && byte_full;
  assign tx_load     = scl_fall &&
                       (((st == ST_ACK_TX) && (after_ack == ST_RDATA)) ||
                        ((st == ST_ACK_RX) && mack));
  assign nack_end    = (st == ST_ACK_RX) && scl_fall && !mack;
  assign tx_idx      = IDX_W'(DATA_W - 1) - IDX_W'(bitcnt);

  eep_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (ptr),
    .wdata_i (shreg),
    .raddr_i (ptr),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      after_ack <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      ptr       <= '0;
      oe        <= 1'b0;
      mack      <= 1'b0;
    end else if (start_det) begin
      st     <= ST_CTRL;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (tx_load) begin
      txreg  <= rd_data;
      oe     <= ~rd_data[DATA_W-1];
      bitcnt <= '0;
      st     <= ST_RDATA;
    end else begin
      unique case (st)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise && !byte_full) begin
            shreg  <= {shreg[DATA_W-2:0], sda_s};
            bitcnt <= bitcnt + CNT_W'(1);
          end else if (byte_end) begin
            bitcnt <= '0;
            if (st == ST_CTRL) begin
              if (ctrl_ok) begin
                oe        <= 1'b1;
                st        <= ST_ACK_TX;
                after_ack <= shreg[0] ? ST_RDATA : ST_ADDR;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_ADDR) begin
              ptr       <= shreg[ADDR_W-1:0];
              oe        <= 1'b1;
              st        <= ST_ACK_TX;
              after_ack <= ST_WDATA;
            end else begin
              ptr       <= page_step(ptr);
              oe        <= 1'b1;
              st        <= ST_ACK_TX;
              after_ack <= ST_WDATA;
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_fall) begin
            oe     <= 1'b0;
            bitcnt <= '0;
            st     <= after_ack;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + CNT_W'(1);
          end else if (tx_done) begin
            oe  <= 1'b0;
            ptr <= seq_step(ptr);
            st  <= ST_ACK_RX;
          end else if (scl_fall) begin
            oe <= ~txreg[tx_idx];
          end
        end
        ST_ACK_RX: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (nack_end) begin
            st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign bus_dat_oe_o = oe;

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_CTRL) && (bitcnt == '0) && !oe);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE) && !oe);

  // R2
  ctrl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reject |=> (st == ST_IDLE) && !oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe);

  // R3
  data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> oe && (st == ST_ACK_TX));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R8
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && (ptr == {ADDR_W{1'b1}})) |=> (ptr == '0));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_end |=> !oe && (st == ST_IDLE));

  // R10
  low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(oe));

endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;

  localparam int QTR = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR = 8'hAB;  // 1010_101_1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic oe;
  logic sda_line;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~oe;

  serial_eeprom_slave u_serial_eeprom_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_clk_i    (scl),
    .bus_dat_i    (sda_line),
    .bus_dat_oe_o (oe),
    .sel_strap_i  (STRAP)
  );

  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got;
  event       got_ev;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8: actual %0h expected none", got);
      end else begin
        chk(tag_q.pop_front(), got, exp_q.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // R10: data line must not move while the clock is high
  logic scl_d = 1'b1;
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_d && (oe !== oe_d)) r10_viol++;
    scl_d <= scl;
    oe_d  <= oe;
  end

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    ack = ~sda_line; qwait();
    scl = 1'b0;   qwait();
    chk(tag, {7'd0, ack}, {7'd0, exp_ack});
  endtask

  task automatic get_byte(input logic give_ack);
    logic [7:0] v;
    v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait();
      scl = 1'b1; qwait();
      v = {v[6:0], sda_line}; qwait();
      scl = 1'b0;
    end
    qwait();
    sda_m = ~give_ack; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
    sda_m = 1'b1;
    got = v;
    ->got_ev;
  endtask

  task automatic point_to(input logic [7:0] a, input string tag);
    bus_start();
    send_chk(CW, 1'b1, tag);
    send_chk(a, 1'b1, tag);
    bus_start();
    send_chk(CR, 1'b1, tag);
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
    bus_start();
    send_chk(CW, 1'b1, "R3");
    send_chk(a, 1'b1, "R4");
    send_chk(d, 1'b1, "R4");
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", {7'd0, oe}, 8'd0);

    // R2: strap mismatch, then bytes that must stay ignored
    bus_start();
    send_chk(8'hA2, 1'b0, "R2");
    send_chk(8'h10, 1'b0, "R2");
    bus_stop();
    // R2: wrong device type
    bus_start();
    send_chk(8'hBA, 1'b0, "R2");
    bus_stop();

    // R4 byte write, R7 random read, R9 release after no acknowledge
    write_byte(8'h10, 8'h5C);
    point_to(8'h10, "R7");
    expect_rd(8'h5C, "R7");
    get_byte(1'b0);
    chk("R9", {7'd0, oe}, 8'd0);
    bus_stop();

    // R5 page write from 0x1E wraps to 0x10
    bus_start();
    send_chk(CW, 1'b1, "R3");
    send_chk(8'h1E, 1'b1, "R5");
    send_chk(8'hA1, 1'b1, "R5");
    send_chk(8'hA2, 1'b1, "R5");
    send_chk(8'hA3, 1'b1, "R5");
    send_chk(8'hA4, 1'b1, "R5");
    bus_stop();
    point_to(8'h1E, "R7");
    expect_rd(8'hA1, "R8");
    get_byte(1'b1);
    expect_rd(8'hA2, "R8");
    get_byte(1'b0);
    bus_stop();
    point_to(8'h10, "R7");
    expect_rd(8'hA3, "R5");
    get_byte(1'b1);
    expect_rd(8'hA4, "R5");
    get_byte(1'b0);
    bus_stop();

    // R2: write with wrong strap must not store
    bus_start();
    send_chk(8'hA2, 1'b0, "R2");
    send_chk(8'h10, 1'b0, "R2");
    send_chk(8'h99, 1'b0, "R2");
    bus_stop();
    point_to(8'h10, "R7");
    expect_rd(8'hA3, "R2");
    get_byte(1'b0);
    bus_stop();

    // R6 current-address read
    write_byte(8'h12, 8'h77);
    point_to(8'h11, "R7");
    expect_rd(8'hA4, "R7");
    get_byte(1'b0);
    bus_stop();
    bus_start();
    send_chk(CR, 1'b1, "R6");
    expect_rd(8'h77, "R6");
    get_byte(1'b0);
    bus_stop();

    // R8 wrap from top address to 0
    write_byte(8'hFF, 8'hE1);
    write_byte(8'h00, 8'hE2);
    point_to(8'hFF, "R8");
    expect_rd(8'hE1, "R8");
    get_byte(1'b1);
    expect_rd(8'hE2, "R8");
    get_byte(1'b0);
    bus_stop();

    // R1 repeated start inside a partial data byte
    write_byte(8'h40, 8'h3C);
    bus_start();
    send_chk(CW, 1'b1, "R1");
    send_chk(8'h40, 1'b1, "R1");
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_chk(CR, 1'b1, "R1");
    expect_rd(8'h3C, "R1");
    get_byte(1'b0);
    bus_stop();

    qwait();
    chk("R10", 8'(r10_viol), 8'd0);
    chk("R8", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule